// File: doc/BRIEF.md
# Batch-Cycle Tracker with Broadcast Steering

This block sits behind a paging receiver's codeword framer. It operates in the cycle-grouped mode of the paging code. Each batch starts with a sync word, which the framer reports on `sync_i`. The 32-bit codewords that follow arrive on `cw_i` with `cw_valid_i`. The block looks for a programmable reserved address codeword, the batch-zero identifier, in the first codeword position after a sync. When it finds one, it aligns a batch counter to zero. The counter then steps once per sync through a cycle of 5 or 15 batches.

The function bits of the identifier tell whether broadcast message data follows. After the first identifier that follows a preamble, the block sends each message codeword to a broadcast output until an address or idle codeword ends the message. The batch counter keeps its phase across a new preamble. An identifier that lands at a nonzero index therefore shows that a transmission was not started at a whole number of cycles. This is recorded in a sticky flag.

In plain mode (`mode_i` low), the identifier is an ordinary address. Nothing is tracked and all outputs stay at zero.

Top module: `bct_tracker`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `batch_idx_o`, `cycle_start_o`, `bcast_present_o`, `bcast_valid_o` and `misalign_o` are 0.
- R2: An identifier is a non-idle codeword with bit 31 = 0 and bits 30:13 equal to `bzi_addr_i`, taken in the first `cw_valid_i` cycle after a `sync_i`. When it is taken, `cycle_start_o` is high for the next cycle and `batch_idx_o` becomes 0. The same address in any other codeword position has no effect.
- R3: Once an identifier has been seen, each `sync_i` advances `batch_idx_o` by one. The index wraps to 0 after index 4 when `long_cycle_i` = 0, and after index 14 when `long_cycle_i` = 1. Before the first identifier the index stays at 0.
- R4: `bcast_present_o` is updated with every identifier. It is 0 when the identifier's function bits 12:11 are 2'b11, and 1 for any other value.
- R5: After an identifier with function bits other than 2'b11, taken in the first cycle after a `preamble_i`, each message codeword (bit 31 = 1, not idle) pulses `bcast_valid_o` one cycle later, with `bcast_data_o` = bits 30:11. This capture continues across sync words.
- R6: Capture ends at the first address codeword or idle codeword (32'h7A89C197). Message codewords after that do not pulse `bcast_valid_o`.
- R7: An identifier that is not the first one after a preamble does not start a capture, whatever its function bits.
- R8: An identifier taken while `batch_idx_o` is nonzero sets `misalign_o`. The flag stays set until plain mode is entered or reset is applied, and the index still realigns to 0.
- R9: With `mode_i` low, `batch_idx_o`, `cycle_start_o`, `bcast_present_o`, `bcast_valid_o` and `misalign_o` are 0 from the next cycle on, whatever the other inputs.
- R10: A codeword that arrives in the same cycle as `sync_i` belongs to the batch before the sync. It is never taken as an identifier, and a message in that cycle is still captured. The next codeword is the candidate position.
- R11: `preamble_i` does not change `batch_idx_o` or `misalign_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 = cycle-grouped tracking, 0 = plain mode |
| long_cycle_i | input | 1 | 0 = 5-batch cycle, 1 = 15-batch cycle |
| bzi_addr_i | input | 18 | Address field of the batch-zero identifier |
| preamble_i | input | 1 | One-cycle pulse when a preamble is found |
| sync_i | input | 1 | One-cycle pulse when a sync word is found |
| cw_valid_i | input | 1 | `cw_i` holds a received codeword |
| cw_i | input | 32 | Codeword, bit 31 = type flag |
| batch_idx_o | output | 4 | Batch index within the cycle |
| cycle_start_o | output | 1 | One-cycle pulse after an identifier is taken |
| bcast_present_o | output | 1 | Latest identifier announced broadcast data |
| bcast_valid_o | output | 1 | `bcast_data_o` holds a broadcast word |
| bcast_data_o | output | 20 | Message field of the broadcast word |
| misalign_o | output | 1 | Sticky: identifier arrived off cycle phase |

## Verification
Two events can fall in the same cycle. One is a batch step caused by `sync_i`. The other is the steering of a message codeword to the broadcast output, or the rejection of an identifier-shaped codeword. The bench drives `sync_i` together with a broadcast message, and checks that the index advances and the word is emitted in the same following cycle. It then drives `sync_i` together with an identifier address. The bench checks that this codeword is not taken as an identifier: the index moves on and there is no cycle-start pulse. The codeword after a sync-plus-message cycle must still be recognised as an identifier.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int unsigned CW_W   = 32;
  localparam int unsigned ADDR_W = 18;
  localparam int unsigned FB_W   = 2;
  localparam int unsigned DATA_W = 20;
  localparam logic [CW_W-1:0] IDLE_CW = 32'h7A89C197;

  localparam int unsigned TYPE_BIT = CW_W - 1;
  localparam int unsigned ADDR_LSB = TYPE_BIT - ADDR_W;
  localparam int unsigned FB_LSB   = ADDR_LSB - FB_W;
  localparam int unsigned DATA_LSB = TYPE_BIT - DATA_W;

  localparam logic [FB_W-1:0] FB_NO_BCAST = '1;

  typedef struct packed {
    logic              is_msg;
    logic              is_addr;
    logic              is_idle;
    logic              is_bzi;
    logic [FB_W-1:0]   fbits;
    logic [DATA_W-1:0] data;
  } cw_info_t;
endpackage

// File: rtl/bct_cw_decode.sv
module bct_cw_decode
  import bct_pkg::*;
(
  input  logic              mode_i,
  input  logic              after_sync_i,
  input  logic [ADDR_W-1:0] bzi_addr_i,
  input  logic              cw_valid_i,
  input  logic [CW_W-1:0]   cw_i,
  output cw_info_t          info_o
);
  logic              idle_match;
  logic [ADDR_W-1:0] addr_field;

  assign idle_match = (cw_i == IDLE_CW);
  assign addr_field = cw_i[TYPE_BIT-1 -: ADDR_W];

  always_comb begin
    info_o.is_idle = cw_valid_i && idle_match;
    info_o.is_msg  = cw_valid_i && cw_i[TYPE_BIT] && !idle_match;
    info_o.is_addr = cw_valid_i && !cw_i[TYPE_BIT] && !idle_match;
    // identifier only in the first slot after a sync, tracking mode only
    info_o.is_bzi  = mode_i && after_sync_i && info_o.is_addr &&
                     (addr_field == bzi_addr_i);
    info_o.fbits   = cw_i[FB_LSB +: FB_W];
    info_o.data    = cw_i[DATA_LSB +: DATA_W];
  end
endmodule

// File: rtl/bct_cycle_ctr.sv
module bct_cycle_ctr #(
  parameter int unsigned SHORT_LEN = 5,
  parameter int unsigned LONG_LEN  = 15,
  parameter int unsigned IDX_W     = $clog2(LONG_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             long_cycle_i,
  input  logic             sync_i,
  input  logic             cw_valid_i,
  input  logic             is_bzi_i,
  output logic             after_sync_o,
  output logic [IDX_W-1:0] batch_idx_o,
  output logic             cycle_start_o,
  output logic             misalign_o
);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LEN - 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_LEN - 1);

  logic             locked_q;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] base_idx;
  logic [IDX_W-1:0] idx_d;

  assign last_idx = long_cycle_i ? LONG_LAST : SHORT_LAST;
  assign base_idx = is_bzi_i ? '0 : batch_idx_o;

  always_comb begin
    idx_d = base_idx;
    if (sync_i && (locked_q || is_bzi_i))
      idx_d = (base_idx >= last_idx) ? '0 : base_idx + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q      <= 1'b0;
      after_sync_o  <= 1'b0;
      batch_idx_o   <= '0;
      cycle_start_o <= 1'b0;
      misalign_o    <= 1'b0;
    end else if (!mode_i) begin
      locked_q      <= 1'b0;
      after_sync_o  <= 1'b0;
      batch_idx_o   <= '0;
      cycle_start_o <= 1'b0;
      misalign_o    <= 1'b0;
    end else begin
      // a codeword sharing the sync cycle closes the old batch
      if (sync_i)          after_sync_o <= 1'b1;
      else if (cw_valid_i) after_sync_o <= 1'b0;
      cycle_start_o <= is_bzi_i;
      if (is_bzi_i) begin
        locked_q <= 1'b1;
        if (locked_q && (batch_idx_o != '0)) misalign_o <= 1'b1;
      end
      batch_idx_o <= idx_d;
    end
  end
endmodule

// File: rtl/bct_bcast_steer.sv
module bct_bcast_steer
  import bct_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              preamble_i,
  input  cw_info_t          info_i,
  output logic              bcast_present_o,
  output logic              bcast_valid_o,
  output logic [DATA_W-1:0] bcast_data_o
);
  logic first_cycle_q;
  logic capture_q;
  logic announces;

  assign announces = (info_i.fbits != FB_NO_BCAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_cycle_q   <= 1'b0;
      capture_q       <= 1'b0;
      bcast_present_o <= 1'b0;
      bcast_valid_o   <= 1'b0;
      bcast_data_o    <= '0;
    end else if (!mode_i) begin
      first_cycle_q   <= 1'b0;
      capture_q       <= 1'b0;
      bcast_present_o <= 1'b0;
      bcast_valid_o   <= 1'b0;
    end else begin
      bcast_valid_o <= capture_q && info_i.is_msg;
      if (capture_q && info_i.is_msg) bcast_data_o <= info_i.data;
      if (info_i.is_bzi) bcast_present_o <= announces;
      if (preamble_i) begin
        first_cycle_q <= 1'b1;
        capture_q     <= 1'b0;
      end else if (info_i.is_bzi) begin
        first_cycle_q <= 1'b0;
        capture_q     <= first_cycle_q && announces;
      end else if (info_i.is_addr || info_i.is_idle) begin
        capture_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bct_tracker.sv
module bct_tracker #(
  parameter int unsigned SHORT_LEN = 5,
  parameter int unsigned LONG_LEN  = 15,
  parameter int unsigned IDX_W     = $clog2(LONG_LEN)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         long_cycle_i,
  input  logic [17:0]  bzi_addr_i,
  input  logic         preamble_i,
  input  logic         sync_i,
  input  logic         cw_valid_i,
  input  logic [31:0]  cw_i,
  output logic [IDX_W-1:0] batch_idx_o,
  output logic         cycle_start_o,
  output logic         bcast_present_o,
  output logic         bcast_valid_o,
  output logic [19:0]  bcast_data_o,
  output logic         misalign_o
);
  import bct_pkg::*;

  cw_info_t info;
  logic     after_sync;

  bct_cw_decode u_dec (
    .mode_i       (mode_i),
    .after_sync_i (after_sync),
    .bzi_addr_i   (bzi_addr_i),
    .cw_valid_i   (cw_valid_i),
    .cw_i         (cw_i),
    .info_o       (info)
  );

  bct_cycle_ctr #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN),
    .IDX_W     (IDX_W)
  ) u_ctr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_i),
    .long_cycle_i  (long_cycle_i),
    .sync_i        (sync_i),
    .cw_valid_i    (cw_valid_i),
    .is_bzi_i      (info.is_bzi),
    .after_sync_o  (after_sync),
    .batch_idx_o   (batch_idx_o),
    .cycle_start_o (cycle_start_o),
    .misalign_o    (misalign_o)
  );

  bct_bcast_steer u_steer (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mode_i          (mode_i),
    .preamble_i      (preamble_i),
    .info_i          (info),
    .bcast_present_o (bcast_present_o),
    .bcast_valid_o   (bcast_valid_o),
    .bcast_data_o    (bcast_data_o)
  );
endmodule

// File: rtl/bct_tracker_chk.sv
module bct_tracker_chk #(
  parameter int unsigned LONG_LEN = 15,
  parameter int unsigned IDX_W    = $clog2(LONG_LEN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             cw_valid_i,
  input logic             cw_msg_i,
  input logic [IDX_W-1:0] batch_idx_o,
  input logic             cycle_start_o,
  input logic             bcast_present_o,
  input logic             bcast_valid_o,
  input logic             misalign_o
);
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batch_idx_o < IDX_W'(LONG_LEN)); // R3

  AST_START_FROM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |-> $past(cw_valid_i && !cw_msg_i && mode_i)); // R2

  AST_PRESENT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) && !cycle_start_o) |-> $stable(bcast_present_o)); // R4

  AST_VALID_FROM_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_valid_o |-> $past(cw_valid_i && cw_msg_i)); // R5

  AST_MISALIGN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misalign_o && mode_i) |=> misalign_o); // R8

  AST_PLAIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> (!cycle_start_o && !bcast_valid_o && !bcast_present_o &&
                 !misalign_o && batch_idx_o == '0)); // R9
endmodule

bind bct_tracker bct_tracker_chk #(.LONG_LEN(LONG_LEN), .IDX_W(IDX_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mode_i          (mode_i),
  .cw_valid_i      (cw_valid_i),
  .cw_msg_i        (cw_i[31]),
  .batch_idx_o     (batch_idx_o),
  .cycle_start_o   (cycle_start_o),
  .bcast_present_o (bcast_present_o),
  .bcast_valid_o   (bcast_valid_o),
  .misalign_o      (misalign_o)
);

// File: tb/sim_bct_tracker.sv
module sim_bct_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  localparam logic [17:0] ID   = 18'h2A5A5;
  localparam logic [31:0] IDLE = 32'h7A89C197;

  typedef struct packed {
    logic        pre;
    logic        sync;
    logic        vld;
    logic [31:0] cw;
    logic [3:0]  idx;
    logic        cs;
    logic        pres;
    logic        bv;
    logic [19:0] data;
    logic        mis;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] acw(input logic [17:0] a, input logic [1:0] fb);
    return {1'b0, a, fb, 11'd0};
  endfunction

  function automatic logic [31:0] mcw(input logic [19:0] d);
    return {1'b1, d, 11'd0};
  endfunction

  function automatic vec_t mk(input logic pre, input logic sync, input logic vld,
                              input logic [31:0] cw, input logic [3:0] idx,
                              input logic cs, input logic pres, input logic bv,
                              input logic [19:0] data, input logic mis,
                              input logic [3:0] req);
    return '{pre, sync, vld, cw, idx, cs, pres, bv, data, mis, req};
  endfunction

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    mk(1,0,0,32'd0,            0,0,0,0,20'h0,    0,11), // R11 preamble arms capture
    mk(0,1,0,32'd0,            0,0,0,0,20'h0,    0, 3), // R3 unlocked, no step
    mk(0,0,1,acw(ID,2'b00),    0,1,1,0,20'h0,    0, 2), // R2 identifier
    mk(0,0,1,mcw(20'hABCDE),   0,0,1,1,20'hABCDE,0, 5), // R5
    mk(0,0,1,mcw(20'h12345),   0,0,1,1,20'h12345,0, 5), // R5
    mk(0,1,0,32'd0,            1,0,1,0,20'h0,    0, 3), // R3 step
    mk(0,0,1,mcw(20'h0F0F0),   1,0,1,1,20'h0F0F0,0, 5), // R5 across sync
    mk(0,0,1,IDLE,             1,0,1,0,20'h0,    0, 6), // R6 idle ends
    mk(0,0,1,mcw(20'h55555),   1,0,1,0,20'h0,    0, 6), // R6
    mk(0,1,0,32'd0,            2,0,1,0,20'h0,    0, 3), // R3
    mk(0,0,1,acw(18'h11,2'b00),2,0,1,0,20'h0,    0, 2), // R2 other address
    mk(0,1,0,32'd0,            3,0,1,0,20'h0,    0, 3), // R3
    mk(0,1,0,32'd0,            4,0,1,0,20'h0,    0, 3), // R3
    mk(0,1,0,32'd0,            0,0,1,0,20'h0,    0, 3), // R3 wrap after 4
    mk(0,0,1,acw(ID,2'b01),    0,1,1,0,20'h0,    0, 7), // R7 aligned, no capture
    mk(0,0,1,mcw(20'h77777),   0,0,1,0,20'h0,    0, 7), // R7
    mk(0,1,0,32'd0,            1,0,1,0,20'h0,    0, 3), // R3
    mk(0,0,1,acw(ID,2'b11),    0,1,0,0,20'h0,    1, 8), // R8 off phase, R4 no bcast
    mk(0,0,1,mcw(20'h11111),   0,0,0,0,20'h0,    1, 8), // R8 sticky
    mk(0,1,0,32'd0,            1,0,0,0,20'h0,    1, 8), // R8
    mk(0,0,1,acw(18'h1,2'b00), 1,0,0,0,20'h0,    1, 2), // R2
    mk(0,0,1,acw(ID,2'b00),    1,0,0,0,20'h0,    1, 2), // R2 not after sync
    mk(1,0,0,32'd0,            1,0,0,0,20'h0,    1,11), // R11 index kept
    mk(0,1,0,32'd0,            2,0,0,0,20'h0,    1, 3), // R3
    mk(0,0,1,acw(ID,2'b10),    0,1,1,0,20'h0,    1, 4), // R4 present, capture on
    mk(0,1,1,mcw(20'h3C3C3),   1,0,1,1,20'h3C3C3,1,10), // R10 sync + message
    mk(0,0,1,acw(ID,2'b00),    0,1,1,0,20'h0,    1,10), // R10 next slot is candidate
    mk(0,0,1,mcw(20'h24680),   0,0,1,0,20'h0,    1, 6), // R6 ended by address
    mk(0,1,1,acw(ID,2'b11),    1,0,1,0,20'h0,    1,10)  // R10 sync + id shape ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        long_c = 1'b0;
  logic        pre = 1'b0;
  logic        sync = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] cw = '0;
  logic [3:0]  idx;
  logic        cs, pres, bv, mis;
  logic [19:0] data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bct_tracker u0 (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .mode_i          (mode),
    .long_cycle_i    (long_c),
    .bzi_addr_i      (ID),
    .preamble_i      (pre),
    .sync_i          (sync),
    .cw_valid_i      (vld),
    .cw_i            (cw),
    .batch_idx_o     (idx),
    .cycle_start_o   (cs),
    .bcast_present_o (pres),
    .bcast_valid_o   (bv),
    .bcast_data_o    (data),
    .misalign_o      (mis)
  );

  task automatic check(input string req, input logic [3:0] e_idx, input logic e_cs,
                       input logic e_pres, input logic e_bv, input logic [19:0] e_data,
                       input logic e_mis);
    checks++;
    if (idx !== e_idx || cs !== e_cs || pres !== e_pres || bv !== e_bv ||
        mis !== e_mis || (e_bv && data !== e_data)) begin
      errors++;
      $display("FAIL %s actual idx=%0d cs=%b pres=%b bv=%b data=%h mis=%b expected idx=%0d cs=%b pres=%b bv=%b data=%h mis=%b",
               req, idx, cs, pres, bv, data, mis, e_idx, e_cs, e_pres, e_bv, e_data, e_mis);
    end
  endtask

  task automatic step(input logic p, input logic s, input logic v, input logic [31:0] c);
    pre = p; sync = s; vld = v; cw = c;
    @(negedge clk);
    pre = 1'b0; sync = 1'b0; vld = 1'b0; cw = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 in reset", 0, 0, 0, 0, 20'h0, 0);
    mode = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 0, 0, 0, 0, 20'h0, 0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].pre, TBL[i].sync, TBL[i].vld, TBL[i].cw);
      checks++;
      if (idx !== TBL[i].idx || cs !== TBL[i].cs || pres !== TBL[i].pres ||
          bv !== TBL[i].bv || mis !== TBL[i].mis || (TBL[i].bv && data !== TBL[i].data)) begin
        errors++;
        $display("FAIL R%0d vec %0d actual idx=%0d cs=%b pres=%b bv=%b data=%h mis=%b expected idx=%0d cs=%b pres=%b bv=%b data=%h mis=%b",
                 TBL[i].req, i, idx, cs, pres, bv, data, mis,
                 TBL[i].idx, TBL[i].cs, TBL[i].pres, TBL[i].bv, TBL[i].data, TBL[i].mis);
      end
    end

    // R3 long cycle: wrap after index 14
    do_reset();
    long_c = 1'b1;
    step(0, 1, 0, '0);
    step(0, 0, 1, acw(ID, 2'b11));
    check("R3 long align", 0, 1, 0, 0, 20'h0, 0);
    for (int k = 1; k <= 14; k++) step(0, 1, 0, '0);
    check("R3 long last", 14, 0, 0, 0, 20'h0, 0);
    step(0, 1, 0, '0);
    check("R3 long wrap", 0, 0, 0, 0, 20'h0, 0);
    step(0, 1, 0, '0);
    step(0, 0, 1, acw(ID, 2'b00));
    check("R8 long misalign", 0, 1, 1, 0, 20'h0, 1);

    // R9 plain mode clears state and ignores traffic
    mode = 1'b0;
    @(negedge clk);
    check("R9 enter plain", 0, 0, 0, 0, 20'h0, 0);
    step(1, 0, 0, '0);
    step(0, 1, 0, '0);
    check("R9 sync ignored", 0, 0, 0, 0, 20'h0, 0);
    step(0, 0, 1, acw(ID, 2'b00));
    check("R9 identifier ignored", 0, 0, 0, 0, 20'h0, 0);
    step(0, 0, 1, mcw(20'h9ABCD));
    check("R9 message ignored", 0, 0, 0, 0, 20'h0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule